// File: doc/BRIEF.md
# Partitioned Flash Erase/Program Controller

This block sits between the decoded command strobes of a serial configuration port and a byte-wide flash store held as a register array. The store is split into two partitions: a large main partition of 4096 bytes and a small side partition of 128 bytes. A halt strobe and a partition-change strobe choose which partition the host-side commands act on. The host can erase the whole selected partition, erase one 64-byte page of it, program single bytes, and read bytes back.

Programming follows flash rules. A byte can only lose bits, because new data is ANDed into the stored value. Only an erase brings bits back to 1, and an erase always acts on a page or on the whole partition, never on a single byte. Erase and program act only while the write-enable input is high. An erase sweeps one byte per cycle, and the busy output is high for the whole sweep. Host commands that arrive while busy is high are dropped.

A separate processor read port always reads the main partition. It reads it whatever the host has selected. It has no way to reach the side partition and no way to change any contents.

Top module: `flash_part_ctl`

## Requirements
- R1: After reset the main partition is selected, busy is low, and both read outputs hold FFh.
- R2: A halt strobe selects the main partition. A partition-change strobe selects the side partition only if a halt has been accepted since reset; otherwise it is ignored.
- R3: With write enable high, a total-erase strobe sets every byte of the selected partition to FFh and leaves the other partition unchanged. Busy is high for exactly 4096 cycles on the main partition and 128 cycles on the side partition.
- R4: With write enable high, a page-erase strobe sets to FFh the 64 bytes of the page that address bits [11:6] select, leaves all other bytes unchanged, and holds busy high for exactly 64 cycles.
- R5: While the side partition is selected, a page erase, program or host read whose address is 128 or above does not act. The erase does not start, the program changes nothing, and the read returns FFh.
- R6: A program strobe replaces the addressed byte with the AND of its old value and the write data. It completes in one cycle and leaves busy low.
- R7: With write enable low, erase and program strobes have no effect and busy stays low.
- R8: Every host command strobe that arrives while busy is high is ignored.
- R9: A processor read strobe loads the main-partition byte at the processor address into the processor read output one cycle later, whichever partition is selected.
- R10: A host read strobe loads the selected partition's byte at the host address into the host read output one cycle later.
- R11: When several command strobes arrive in one cycle, only the first of this order is considered: halt, partition change, total erase, page erase, program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| haltStb | input | 1 | Halt command strobe; selects main partition |
| chgPartStb | input | 1 | Partition-change command strobe |
| totalEraseStb | input | 1 | Erase the whole selected partition |
| pageEraseStb | input | 1 | Erase the page selected by addr[11:6] |
| progStb | input | 1 | Program the byte at addr with wrData |
| hostRdStb | input | 1 | Host read of the byte at addr |
| addr | input | 12 | Host byte address |
| wrData | input | 8 | Program data |
| wrEnable | input | 1 | Flash write-enable control bit |
| cpuRdStb | input | 1 | Processor read strobe |
| cpuAddr | input | 12 | Processor byte address (main partition) |
| hostRdData | output | 8 | Host read result |
| cpuRdData | output | 8 | Processor read result |
| busy | output | 1 | High while an erase sweep runs |

## Verification
The assertions assume that every strobe is a clean one-cycle pulse sampled at a clock edge. They also assume that addr and wrEnable are stable during the cycle a strobe is sampled. The bench meets this by driving all inputs on the falling edge and clearing each strobe on the next falling edge. During an erase sweep the assertions assume nothing about the inputs. The bench deliberately fires a program strobe inside a sweep to show that it is dropped, and it fires conflicting strobes together to exercise the priority order.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  parameter int FL_ADDR_W = 12;
  parameter int FL_DATA_W = 8;

  typedef enum logic {ST_IDLE, ST_ERASE} ctlState_e;

  // strobes from control to the array datapath
  typedef struct packed {
    logic                 eraseWr;  // write FFh at idx of part
    logic                 progWr;   // AND data into idx of part
    logic                 hostRd;   // capture host read at idx of part
    logic                 part;     // 0 = main, 1 = side partition
    logic [FL_ADDR_W-1:0] idx;
    logic [FL_DATA_W-1:0] data;
  } dpStrb_t;
endpackage

// File: rtl/flash_ctl_fsm.sv
module flash_ctl_fsm
  import flash_ctl_pkg::*;
#(
  parameter int PAGE_W   = 6,
  parameter int P1_PAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 haltStb,
  input  logic                 chgPartStb,
  input  logic                 totalEraseStb,
  input  logic                 pageEraseStb,
  input  logic                 progStb,
  input  logic                 hostRdStb,
  input  logic [FL_ADDR_W-1:0] addr,
  input  logic [FL_DATA_W-1:0] wrData,
  input  logic                 wrEnable,
  output logic                 busy,
  output dpStrb_t              strb
);
  localparam int P0_BYTES   = 1 << FL_ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int P1_BYTES   = P1_PAGES * PAGE_BYTES;
  localparam logic [FL_ADDR_W:0]   P1_LIM    = (FL_ADDR_W+1)'(P1_BYTES);
  localparam logic [FL_ADDR_W-1:0] P0_LAST   = FL_ADDR_W'(P0_BYTES - 1);
  localparam logic [FL_ADDR_W-1:0] P1_LAST   = FL_ADDR_W'(P1_BYTES - 1);
  localparam logic [FL_ADDR_W-1:0] PAGE_LAST = FL_ADDR_W'(PAGE_BYTES - 1);

  ctlState_e state;
  logic halted, partSel;
  logic [FL_ADDR_W-1:0] cnt, cntLast, base;
  logic idle, inP1, addrOk;
  logic doHalt, doChg, doTotal, doPage, doProg;

  assign idle   = (state == ST_IDLE);
  assign inP1   = ({1'b0, addr} < P1_LIM);
  assign addrOk = !partSel || inP1;

  // fixed priority: halt, change, total, page, program
  always_comb begin
    doHalt  = idle && haltStb;
    doChg   = idle && !haltStb && chgPartStb;
    doTotal = idle && !haltStb && !chgPartStb && totalEraseStb && wrEnable;
    doPage  = idle && !haltStb && !chgPartStb && !totalEraseStb &&
              pageEraseStb && wrEnable && addrOk;
    doProg  = idle && !haltStb && !chgPartStb && !totalEraseStb &&
              !pageEraseStb && progStb && wrEnable && addrOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halted  <= 1'b0;
      partSel <= 1'b0;
      cnt     <= '0;
      cntLast <= '0;
      base    <= '0;
    end else begin
      if (doHalt) begin
        halted  <= 1'b1;
        partSel <= 1'b0;
      end
      if (doChg && halted) partSel <= 1'b1;
      if (doTotal) begin
        state   <= ST_ERASE;
        cnt     <= '0;
        base    <= '0;
        cntLast <= partSel ? P1_LAST : P0_LAST;
      end
      if (doPage) begin
        state   <= ST_ERASE;
        cnt     <= '0;
        base    <= {addr[FL_ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
        cntLast <= PAGE_LAST;
      end
      if (state == ST_ERASE) begin
        cnt <= cnt + 1'b1;
        if (cnt == cntLast) state <= ST_IDLE;
      end
    end
  end

  assign busy = (state == ST_ERASE);

  always_comb begin
    strb.eraseWr = busy;
    strb.progWr  = doProg;
    strb.hostRd  = idle && hostRdStb;
    strb.part    = partSel;
    strb.idx     = busy ? (base | cnt) : addr;
    strb.data    = wrData;
  end

  // R2: an accepted halt always returns to the main partition
  a_r2_halt_main: assert property (@(posedge clk) disable iff (!rstN)
    (haltStb && !busy) |=> !partSel);
  // R8: selection cannot move during a sweep
  a_r8_sel_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(partSel));
  // R7: no sweep starts without write enable
  a_r7_no_we_no_erase: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !wrEnable) |=> !busy);
  // R3: sweep counter stays inside its window
  a_r3_cnt_window: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt <= cntLast));
  // R5: side-partition sweep never leaves its 128 bytes
  a_r5_side_bound: assert property (@(posedge clk) disable iff (!rstN)
    (busy && partSel) |-> ({1'b0, strb.idx} < P1_LIM));
endmodule

// File: rtl/flash_ctl_array.sv
module flash_ctl_array
  import flash_ctl_pkg::*;
#(
  parameter int PAGE_W   = 6,
  parameter int P1_PAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrb_t              strb,
  input  logic                 cpuRdStb,
  input  logic [FL_ADDR_W-1:0] cpuAddr,
  output logic [FL_DATA_W-1:0] hostRdData,
  output logic [FL_DATA_W-1:0] cpuRdData
);
  localparam int P0_BYTES  = 1 << FL_ADDR_W;
  localparam int P1_BYTES  = P1_PAGES << PAGE_W;
  localparam int P1_ADDR_W = $clog2(P1_BYTES);
  localparam logic [FL_ADDR_W:0]   P1_LIM = (FL_ADDR_W+1)'(P1_BYTES);
  localparam logic [FL_DATA_W-1:0] ERASED = '1;

  logic [FL_DATA_W-1:0] mainMem [P0_BYTES];
  logic [FL_DATA_W-1:0] sideMem [P1_BYTES];
  logic [P1_ADDR_W-1:0] sideIdx;
  logic                 idxInSide;

  assign sideIdx   = strb.idx[P1_ADDR_W-1:0];
  assign idxInSide = ({1'b0, strb.idx} < P1_LIM);

  // storage has no reset: flash contents persist
  always_ff @(posedge clk) begin
    if (strb.eraseWr) begin
      if (strb.part) sideMem[sideIdx] <= ERASED;
      else           mainMem[strb.idx] <= ERASED;
    end else if (strb.progWr) begin
      if (strb.part) sideMem[sideIdx] <= sideMem[sideIdx] & strb.data;
      else           mainMem[strb.idx] <= mainMem[strb.idx] & strb.data;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdData <= ERASED;
      cpuRdData  <= ERASED;
    end else begin
      if (strb.hostRd) begin
        if (strb.part) hostRdData <= idxInSide ? sideMem[sideIdx] : ERASED;
        else           hostRdData <= mainMem[strb.idx];
      end
      if (cpuRdStb) cpuRdData <= mainMem[cpuAddr];
    end
  end

  // R3/R4: a swept main byte reads erased afterwards
  a_r3_sweep_ff: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eraseWr && !strb.part) |=> (mainMem[$past(strb.idx)] == ERASED));
  // R6: programming never raises a bit
  a_r6_only_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.progWr && !strb.part) |=>
      ((mainMem[$past(strb.idx)] & ~$past(mainMem[strb.idx])) == '0));
  // R4/R6: erase and program are never requested together
  a_r6_one_writer: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.eraseWr && strb.progWr));
endmodule

// File: rtl/flash_part_ctl.sv
module flash_part_ctl
  import flash_ctl_pkg::*;
#(
  parameter int PAGE_W   = 6,
  parameter int P1_PAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 haltStb,
  input  logic                 chgPartStb,
  input  logic                 totalEraseStb,
  input  logic                 pageEraseStb,
  input  logic                 progStb,
  input  logic                 hostRdStb,
  input  logic [FL_ADDR_W-1:0] addr,
  input  logic [FL_DATA_W-1:0] wrData,
  input  logic                 wrEnable,
  input  logic                 cpuRdStb,
  input  logic [FL_ADDR_W-1:0] cpuAddr,
  output logic [FL_DATA_W-1:0] hostRdData,
  output logic [FL_DATA_W-1:0] cpuRdData,
  output logic                 busy
);
  dpStrb_t strb;

  flash_ctl_fsm #(.PAGE_W(PAGE_W), .P1_PAGES(P1_PAGES)) ctl_i (
    .clk(clk), .rstN(rstN),
    .haltStb(haltStb), .chgPartStb(chgPartStb),
    .totalEraseStb(totalEraseStb), .pageEraseStb(pageEraseStb),
    .progStb(progStb), .hostRdStb(hostRdStb),
    .addr(addr), .wrData(wrData), .wrEnable(wrEnable),
    .busy(busy), .strb(strb)
  );

  flash_ctl_array #(.PAGE_W(PAGE_W), .P1_PAGES(P1_PAGES)) arr_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cpuRdStb(cpuRdStb), .cpuAddr(cpuAddr),
    .hostRdData(hostRdData), .cpuRdData(cpuRdData)
  );
endmodule

// File: tb/flash_part_ctl_tb_top.sv
module flash_part_ctl_tb_top;
  localparam logic [2:0] OP_HALT = 3'd0, OP_CHG = 3'd1, OP_TOT = 3'd2,
                         OP_PAGE = 3'd3, OP_PROG = 3'd4, OP_RD = 3'd5,
                         OP_CPU = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic [11:0] addr;
    logic [7:0]  data;
    logic        we;
    logic [7:0]  expData;
    logic [12:0] expBusy;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 29;
  localparam vec_t VEC [NVEC] = '{
    '{OP_TOT,  12'h000, 8'h00, 1'b1, 8'hFF, 13'd4096, 4'd3},  // R3 main
    '{OP_HALT, 12'h000, 8'h00, 1'b1, 8'hFF, 13'd0,    4'd2},
    '{OP_CHG,  12'h000, 8'h00, 1'b1, 8'hFF, 13'd0,    4'd2},  // R2 side
    '{OP_TOT,  12'h000, 8'h00, 1'b1, 8'hFF, 13'd128,  4'd3},  // R3 side
    '{OP_PROG, 12'h005, 8'hA5, 1'b1, 8'hFF, 13'd0,    4'd6},
    '{OP_RD,   12'h005, 8'h00, 1'b1, 8'hA5, 13'd0,    4'd10}, // R10
    '{OP_PROG, 12'h005, 8'h3C, 1'b1, 8'hFF, 13'd0,    4'd6},
    '{OP_RD,   12'h005, 8'h00, 1'b1, 8'h24, 13'd0,    4'd6},  // R6 AND
    '{OP_PROG, 12'h0C8, 8'h00, 1'b1, 8'hFF, 13'd0,    4'd5},
    '{OP_RD,   12'h0C8, 8'h00, 1'b1, 8'hFF, 13'd0,    4'd5},  // R5
    '{OP_HALT, 12'h000, 8'h00, 1'b1, 8'hFF, 13'd0,    4'd2},
    '{OP_RD,   12'h005, 8'h00, 1'b1, 8'hFF, 13'd0,    4'd3},  // main untouched
    '{OP_PROG, 12'h005, 8'h5A, 1'b0, 8'hFF, 13'd0,    4'd7},
    '{OP_RD,   12'h005, 8'h00, 1'b1, 8'hFF, 13'd0,    4'd7},  // R7
    '{OP_PROG, 12'h047, 8'h11, 1'b1, 8'hFF, 13'd0,    4'd6},
    '{OP_PROG, 12'h080, 8'h22, 1'b1, 8'hFF, 13'd0,    4'd6},
    '{OP_PAGE, 12'h040, 8'h00, 1'b1, 8'hFF, 13'd64,   4'd4},  // R4
    '{OP_RD,   12'h047, 8'h00, 1'b1, 8'hFF, 13'd0,    4'd4},
    '{OP_RD,   12'h080, 8'h00, 1'b1, 8'h22, 13'd0,    4'd4},
    '{OP_CPU,  12'h080, 8'h00, 1'b1, 8'h22, 13'd0,    4'd9},  // R9
    '{OP_HALT, 12'h000, 8'h00, 1'b1, 8'hFF, 13'd0,    4'd2},
    '{OP_CHG,  12'h000, 8'h00, 1'b1, 8'hFF, 13'd0,    4'd2},
    '{OP_RD,   12'h005, 8'h00, 1'b1, 8'h24, 13'd0,    4'd2},
    '{OP_CPU,  12'h080, 8'h00, 1'b1, 8'h22, 13'd0,    4'd9},
    '{OP_PAGE, 12'h080, 8'h00, 1'b1, 8'hFF, 13'd0,    4'd5},  // R5 page 2
    '{OP_PAGE, 12'h000, 8'h00, 1'b1, 8'hFF, 13'd64,   4'd4},
    '{OP_RD,   12'h005, 8'h00, 1'b1, 8'hFF, 13'd0,    4'd4},
    '{OP_PAGE, 12'h040, 8'h00, 1'b0, 8'hFF, 13'd0,    4'd7},
    '{OP_HALT, 12'h000, 8'h00, 1'b1, 8'hFF, 13'd0,    4'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltStb = 0, chgPartStb = 0, totalEraseStb = 0, pageEraseStb = 0;
  logic progStb = 0, hostRdStb = 0, wrEnable = 0, cpuRdStb = 0;
  logic [11:0] addr = '0, cpuAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  hostRdData, cpuRdData;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_part_ctl dut_i (
    .clk(clk), .rstN(rstN), .haltStb(haltStb), .chgPartStb(chgPartStb),
    .totalEraseStb(totalEraseStb), .pageEraseStb(pageEraseStb),
    .progStb(progStb), .hostRdStb(hostRdStb), .addr(addr), .wrData(wrData),
    .wrEnable(wrEnable), .cpuRdStb(cpuRdStb), .cpuAddr(cpuAddr),
    .hostRdData(hostRdData), .cpuRdData(cpuRdData), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearStb();
    haltStb = 0; chgPartStb = 0; totalEraseStb = 0; pageEraseStb = 0;
    progStb = 0; hostRdStb = 0; cpuRdStb = 0;
  endtask

  task automatic waitIdle(output int cyc);
    cyc = 0;
    while (busy && cyc < 10000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic runOp(input logic [2:0] op, input logic [11:0] a,
                       input logic [7:0] d, input logic we, output int cyc);
    addr = a; wrData = d; wrEnable = we; cpuAddr = a;
    case (op)
      OP_HALT: haltStb = 1;
      OP_CHG:  chgPartStb = 1;
      OP_TOT:  totalEraseStb = 1;
      OP_PAGE: pageEraseStb = 1;
      OP_PROG: progStb = 1;
      OP_RD:   hostRdStb = 1;
      default: cpuRdStb = 1;
    endcase
    @(negedge clk);
    clearStb();
    waitIdle(cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 hostRdData", hostRdData, 8'hFF);
    chk("R1 cpuRdData", cpuRdData, 8'hFF);
    rstN = 1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      runOp(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].we, cyc);
      if (VEC[i].op == OP_RD)
        chk($sformatf("R%0d vec%0d host", VEC[i].req, i), hostRdData, VEC[i].expData);
      else if (VEC[i].op == OP_CPU)
        chk($sformatf("R%0d vec%0d cpu", VEC[i].req, i), cpuRdData, VEC[i].expData);
      else
        chk($sformatf("R%0d vec%0d busy", VEC[i].req, i), cyc, VEC[i].expBusy);
    end

    // R8: program strobe inside a sweep is dropped (main partition page 3)
    addr = 12'h0C0; wrEnable = 1; pageEraseStb = 1;
    @(negedge clk);
    clearStb();
    chk("R8 busy raised", busy, 1);
    addr = 12'h010; wrData = 8'h00; progStb = 1;
    @(negedge clk);
    clearStb();
    waitIdle(cyc);
    chk("R8 sweep length", cyc + 1, 64);
    runOp(OP_RD, 12'h010, 8'h00, 1, cyc);
    chk("R8 program ignored", hostRdData, 8'hFF);

    // R11: page erase outranks program in the same cycle
    addr = 12'h300; wrData = 8'h0F; wrEnable = 1; pageEraseStb = 1; progStb = 1;
    @(negedge clk);
    clearStb();
    waitIdle(cyc);
    chk("R11 page wins busy", cyc, 64);
    runOp(OP_RD, 12'h300, 8'h00, 1, cyc);
    chk("R11 program dropped", hostRdData, 8'hFF);

    // R2: change without a prior halt is ignored after reset
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    runOp(OP_CHG, 12'h000, 8'h00, 1, cyc);
    runOp(OP_PROG, 12'h009, 8'h99, 1, cyc);
    runOp(OP_HALT, 12'h000, 8'h00, 1, cyc);
    runOp(OP_CHG, 12'h000, 8'h00, 1, cyc);
    runOp(OP_RD, 12'h009, 8'h00, 1, cyc);
    chk("R2 side untouched", hostRdData, 8'hFF);
    runOp(OP_HALT, 12'h000, 8'h00, 1, cyc);
    runOp(OP_RD, 12'h009, 8'h00, 1, cyc);
    chk("R2 prog went to main", hostRdData, 8'h99);
    runOp(OP_CPU, 12'h009, 8'h00, 1, cyc);
    chk("R9 cpu main read", cpuRdData, 8'h99);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule